// File: doc/BRIEF.md
# Multi-Counter Event Performance Monitor

This block is a performance monitor with five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event, picked from a 256-bit vector of event pulses. Software reaches the counters through a simple register port. Each counter has its own register window: event select, count value, counter enable and overflow flag. A global control register holds the master enable and a clear-all command, and it reports how many event counters are built.

An 8-bit event select picks the pulse to count: the source interface in the upper three bits and the event code in the lower five. Sources 0 to 4 are slave-side interfaces and take only codes 0x00 to 0x13. Sources 5 to 7 are master-side interfaces and take only codes 0x14 to 0x1A. A select outside these ranges never counts. When a counter wraps from all ones to zero, it sets a sticky overflow flag. That flag drives the counter's own interrupt line until software clears it.

Top module: `perf_monitor`

## Requirements
- R1: After reset, every count value, counter enable, event select, overflow flag and interrupt line is 0, and the master enable reads 0.
- R2: The window for counter i starts at address i*0x1000. Within it, the event select is at offset 0x0, the count value at 0x4, the counter enable (bit 0) at 0x8 and the overflow flag (bit 0) at 0xC. The global control register is at address 0x100.
- R3: A counter goes up by exactly one on each clock in which the master enable (global bit 0) is 1, its own enable is 1, and, for an event counter, the pulse at index select[7:0] (source*32 + code) of the event vector is high. The cycle counter counts every such clock.
- R4: Event select bits 7:5 give the source and bits 4:0 give the code. The select is legal only for a source from 0 to 4 with a code from 0x00 to 0x13, or a source from 5 to 7 with a code from 0x14 to 0x1A. A counter whose select is illegal never counts, even when its pulse is high.
- R5: A counter does not change while the master enable is 0 or while its own enable is 0.
- R6: A write to a count value loads the written data. In the same clock, this write takes priority over an increment.
- R7: A wrap from all ones to zero sets that counter's overflow flag. The counter's interrupt line is high while its flag is set. Writing 1 to flag bit 0 clears it, and writing 0 has no effect. When a wrap and a clearing write fall in the same clock, the flag stays set.
- R8: Writing 1 to global bit 1 clears all five count values. Overflow flags do not change, and bit 1 always reads back 0.
- R9: Global bits 15:11 read the number of event counters, which is 4 by default. The cycle counter is not included.
- R10: The cycle counter's event select always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | 256 | Event pulses, indexed by source*32 + code |
| ovf_irq | output | 5 | Per-counter overflow interrupt, bit i for counter i |

## Verification
The hardest cases to reach from the ports are the same-clock collisions: a count wrap in the same clock as a write that clears the overflow flag, and an increment in the same clock as a software load of the count. To reach a wrap, the bench first preloads a counter to 0xFFFFFFFE or 0xFFFFFFFF with the master enable off. It then sets the master enable with a write whose landing clock is known, so that it can place the clearing write, or the count load, exactly on the clock where the increment happens. Each count test runs its event pattern inside an enable window of known length, so the expected count can be worked out by hand.

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int NUM_EVT      = 4,
  parameter int DW           = 32,
  parameter int AW           = 16,
  parameter int SRC_W        = 3,
  parameter int CODE_W       = 5,
  parameter int SLV_SRCS     = 5,
  parameter int SLV_CODE_MAX = 'h13,
  parameter int MST_CODE_MIN = 'h14,
  parameter int MST_CODE_MAX = 'h1A
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [AW-1:0]                   reg_addr,
  input  logic [DW-1:0]                   reg_wdata,
  output logic [DW-1:0]                   reg_rdata,
  input  logic [(1<<(SRC_W+CODE_W))-1:0]  evt_in,
  output logic [NUM_EVT:0]                ovf_irq
);
  localparam int NUM   = NUM_EVT + 1;
  localparam int SEL_W = SRC_W + CODE_W;
  localparam int WIN_W = AW - 12;

  logic [SEL_W-1:0] sel_q [NUM];
  logic [DW-1:0]    cnt_q [NUM];
  logic [NUM-1:0]   en_q, ovf_q, inc, wrap, wr_sel, wr_cnt, wr_en, wr_ovf;
  logic             cen_q;

  wire [WIN_W-1:0] win     = reg_addr[AW-1:12];
  wire [11:0]      off     = reg_addr[11:0];
  wire             glob_hit = (reg_addr == AW'('h100));
  wire             clr_all  = reg_wr && glob_hit && reg_wdata[1];

  function automatic logic sel_legal(input logic [SEL_W-1:0] s);
    int src, code;
    src  = int'(s[SEL_W-1:CODE_W]);
    code = int'(s[CODE_W-1:0]);
    if (src < SLV_SRCS) return code <= SLV_CODE_MAX;
    return (code >= MST_CODE_MIN) && (code <= MST_CODE_MAX);
  endfunction

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      wr_sel[i] = reg_wr && (win == WIN_W'(i)) && (off == 12'h000);
      wr_cnt[i] = reg_wr && (win == WIN_W'(i)) && (off == 12'h004);
      wr_en[i]  = reg_wr && (win == WIN_W'(i)) && (off == 12'h008);
      wr_ovf[i] = reg_wr && (win == WIN_W'(i)) && (off == 12'h00C);
      if (i == 0) inc[i] = cen_q && en_q[i];
      else        inc[i] = cen_q && en_q[i] && sel_legal(sel_q[i]) && evt_in[sel_q[i]];
      wrap[i] = inc[i] && (&cnt_q[i]) && !wr_cnt[i] && !clr_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q <= 1'b0;
      en_q  <= '0;
      ovf_q <= '0;
      for (int i = 0; i < NUM; i++) begin
        sel_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (reg_wr && glob_hit) cen_q <= reg_wdata[0];
      for (int i = 0; i < NUM; i++) begin
        if (wr_en[i]) en_q[i] <= reg_wdata[0];
        if (wr_sel[i] && i != 0) sel_q[i] <= reg_wdata[SEL_W-1:0];
        if (clr_all)        cnt_q[i] <= '0;
        else if (wr_cnt[i]) cnt_q[i] <= reg_wdata;
        else if (inc[i])    cnt_q[i] <= cnt_q[i] + DW'(1);
        if (wrap[i])                         ovf_q[i] <= 1'b1;
        else if (wr_ovf[i] && reg_wdata[0])  ovf_q[i] <= 1'b0;
      end
    end
  end

  assign ovf_irq = ovf_q;

  always_comb begin
    reg_rdata = '0;
    if (glob_hit) begin
      reg_rdata[15:11] = 5'(NUM_EVT);
      reg_rdata[0]     = cen_q;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (win == WIN_W'(i)) begin
          case (off)
            12'h000: reg_rdata = DW'(sel_q[i]);
            12'h004: reg_rdata = cnt_q[i];
            12'h008: reg_rdata = DW'(en_q[i]);
            12'h00C: reg_rdata = DW'(ovf_q[i]);
            default: reg_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk #(
  parameter int NUM = 5,
  parameter int DW  = 32,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [DW-1:0]  cnt_q [NUM],
  input logic           cen_q,
  input logic [NUM-1:0] ovf_irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> ovf_irq == '0);

  for (genvar g = 0; g < NUM; g++) begin : per_cnt
    // R6
    cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(g*4096 + 4)) |=> cnt_q[g] == $past(reg_wdata));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_irq[g]) |-> $past(cnt_q[g]) == {DW{1'b1}});
    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq[g] && !(reg_wr && reg_addr == AW'(g*4096 + 12) && reg_wdata[0])) |=> ovf_irq[g]);
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + DW'(1)));
    // R5
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_q && !reg_wr) |=> $stable(cnt_q[g]));
  end
endmodule

bind perf_monitor perf_monitor_chk #(.NUM(NUM), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt_q(cnt_q), .cen_q(cen_q), .ovf_irq(ovf_irq)
);

// File: tb/perf_monitor_tb_top.sv
`timescale 1ns/1ps
module perf_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [255:0] evt = '0;
  logic [4:0]  ovf_irq;
  logic        chk_stb = 1'b0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  perf_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt), .ovf_irq(ovf_irq)
  );

  function automatic logic [15:0] ra(input int idx, input int off);
    return 16'(idx * 4096 + off);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    chk_stb = 1'b1;
    @(negedge clk);
    chk_stb = 1'b0;
  endtask

  task automatic chk_now(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (chk_stb && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk_now(reg_rdata, e, t);
    end
  end

  task automatic window(input int n);
    wr(16'h0100, 32'h1);
    repeat (n) @(negedge clk);
    wr(16'h0100, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9
    rd(16'h0100, 32'h0000_2000, "R1/R9 global after reset");
    rd(ra(2, 4), 32'h0, "R1 count after reset");
    rd(ra(3, 12), 32'h0, "R1 overflow after reset");
    chk_now(32'(ovf_irq), 32'h0, "R1 irq after reset");
    // R10
    wr(ra(0, 0), 32'h55);
    rd(ra(0, 0), 32'h0, "R10 cycle select ignored");
    // R2 R4 setup
    wr(ra(1, 0), 32'h45);
    wr(ra(2, 0), 32'hD5);
    wr(ra(3, 0), 32'h34);
    wr(ra(4, 0), 32'hA3);
    for (int i = 0; i < 5; i++) wr(ra(i, 8), 32'h1);
    rd(ra(1, 0), 32'h45, "R2 select readback");
    rd(ra(4, 8), 32'h1, "R2 enable readback");
    evt[69] = 1'b1; evt[213] = 1'b1; evt[52] = 1'b1; evt[163] = 1'b1;
    window(9);
    rd(ra(0, 4), 32'd10, "R3 cycle count");
    rd(ra(1, 4), 32'd10, "R3 slave event count");
    rd(ra(2, 4), 32'd10, "R3 master event count");
    rd(ra(3, 4), 32'd0, "R4 illegal slave code");
    rd(ra(4, 4), 32'd0, "R4 illegal master code");
    // R5
    wr(ra(2, 8), 32'h0);
    window(4);
    rd(ra(1, 4), 32'd15, "R5 enabled counter");
    rd(ra(2, 4), 32'd10, "R5 disabled counter");
    rd(ra(0, 4), 32'd15, "R5 cycle count");
    repeat (3) @(negedge clk);
    rd(ra(1, 4), 32'd15, "R5 master off holds");
    // R6
    wr(16'h0100, 32'h1);
    wr(ra(1, 4), 32'h100);
    repeat (2) @(negedge clk);
    wr(16'h0100, 32'h0);
    rd(ra(1, 4), 32'h103, "R6 write beats increment");
    // R7
    wr(ra(1, 4), 32'hFFFF_FFFE);
    window(1);
    rd(ra(1, 4), 32'h0, "R7 wrapped count");
    rd(ra(1, 12), 32'h1, "R7 flag set");
    chk_now(32'(ovf_irq), 32'h2, "R7 irq line");
    wr(ra(1, 12), 32'h0);
    rd(ra(1, 12), 32'h1, "R7 write 0 no effect");
    wr(ra(1, 12), 32'h1);
    rd(ra(1, 12), 32'h0, "R7 write 1 clears");
    chk_now(32'(ovf_irq), 32'h0, "R7 irq cleared");
    wr(ra(1, 4), 32'hFFFF_FFFF);
    wr(16'h0100, 32'h1);
    wr(ra(1, 12), 32'h1);
    wr(16'h0100, 32'h0);
    rd(ra(1, 4), 32'h1, "R7 count after collision");
    rd(ra(1, 12), 32'h1, "R7 set wins over clear");
    // R8
    wr(16'h0100, 32'h2);
    rd(ra(1, 4), 32'h0, "R8 event count cleared");
    rd(ra(0, 4), 32'h0, "R8 cycle count cleared");
    rd(16'h0100, 32'h0000_2000, "R8 bit1 reads 0");
    rd(ra(1, 12), 32'h1, "R8 flag kept");
    // R3 pulse pattern
    evt[69] = 1'b0;
    wr(16'h0100, 32'h1);
    for (int k = 0; k < 6; k++) begin
      evt[69] = (k % 2 == 0);
      @(negedge clk);
    end
    evt[69] = 1'b0;
    wr(16'h0100, 32'h0);
    rd(ra(1, 4), 32'd3, "R3 alternating pulses");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule